// File: doc/BRIEF.md
# Exhaustive Adder Sweep Tester

This block checks an adder against a reference by stepping through every operand pair, one pair per clock cycle. It contains both the adder under test, whose output can be corrupted on purpose through a two-bit fault selector, and the controller that drives it. The controller owns a single counter whose upper half is operand A and whose lower half is operand B. While a sweep is active, each cycle presents one pair, compares the adder's sum with A+B truncated to the operand width, and moves to the next pair.

A sweep is started by a go pulse after reset. When a comparison fails, the tester stops on that pair and raises its error output, so that an operator can read the failing operands and the wrong sum. A further go pulse clears the error and continues from the next pair. Once the all-ones pair has been checked, the tester stops for good and stays there until the next reset. At the default width of 16 bits the sweep covers 2^32 pairs, about 160 seconds at 27 MHz. Tests run the same logic at a reduced width.

Top module: `adder_sweep_tester`

## Requirements
- R1: A synchronous active-low reset sets both operands to zero and clears `sweeping` and `fault_seen`.
- R2: After reset the tester waits with `sweeping` low until `go` is sampled high. It then raises `sweeping` on the next cycle.
- R3: The presented pair is a counter with A in the upper WIDTH bits and B in the lower WIDTH bits. It starts at zero and rises by one on each cycle in which the sweep checks a pair that matches and is not the last pair.
- R4: When `sum_out` differs from (A+B) mod 2^WIDTH while sweeping, on the next cycle `fault_seen` is 1, `sweeping` is 0, and the failing operands are still presented.
- R5: While halted on a mismatch with `go` low, the operands, the sum and `fault_seen` hold their values.
- R6: A `go` pulse while halted clears `fault_seen` on the next cycle. The sweep then continues with the next pair, or it finishes if the halted pair was the last pair.
- R7: After the all-ones pair has been checked and no halt is pending, `sweeping` and `fault_seen` stay low and the operands stay all ones until reset. A `go` pulse in this state has no effect.
- R8: A `go` pulse while sweeping has no effect. The pair still advances by exactly one.
- R9: With `fault_sel` = 0 the adder output always equals (A+B) mod 2^WIDTH, and the sweep completes with no halt.
- R10: With `fault_sel` = 1, only the pair A=1, B=1 is corrupted, and it yields 3. The sweep halts exactly once.
- R11: With `fault_sel` = 2, the sum has its most significant bit inverted exactly when A equals B and A is a power of two. A sweep therefore halts WIDTH times.
- R12: With `fault_sel` = 3, the sum has bit 0 inverted exactly when B is all ones and A is either zero or all ones. A sweep therefore halts twice, and the second halt is on the last pair.
- R13: Every pair is checked in exactly one sweeping cycle, so a sweep spends exactly 2^(2*WIDTH) cycles with `sweeping` high, whatever the number of halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start, or resume after a halt (one-cycle pulse) |
| fault_sel | input | 2 | Fault pattern applied inside the adder under test |
| op_a | output | WIDTH | Operand A currently presented |
| op_b | output | WIDTH | Operand B currently presented |
| sum_out | output | WIDTH | Sum produced by the adder under test for the presented pair |
| fault_seen | output | 1 | High while halted on a mismatching pair |
| sweeping | output | 1 | High while pairs are being checked |

## Verification
The hardest case to reach is a mismatch on the all-ones pair. Resuming from that halt must end the sweep rather than wrap the counter back to zero, and the only way to get there is a sweep of the entire input space. The bench therefore sets WIDTH to 4, so that each sweep has 256 pairs, and runs fault pattern 3, whose second corrupted pair is the final one. It also pulses go in the middle of a clean sweep and after completion, and it compares a behavioural model against the ports on every cycle.

// File: rtl/sweep_pkg.sv
// Shared definitions for the adder sweep tester: controller states and
// fault-pattern codes. Assumes a two-bit fault selector.
package sweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_PAUSE = 2'd2,
        ST_END   = 2'd3
    } sweep_state_t;

    localparam logic [1:0] FM_CLEAN = 2'd0;
    localparam logic [1:0] FM_ONE   = 2'd1;
    localparam logic [1:0] FM_POW2  = 2'd2;
    localparam logic [1:0] FM_EDGE  = 2'd3;

endpackage

// File: rtl/faulty_adder.sv
// Adder under test. It produces a + b truncated to WIDTH bits and, depending
// on the fault selector, corrupts the result for a small fixed set of pairs.
// Assumes WIDTH >= 2. The logic is purely combinational.
module faulty_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] sum
);
    import sweep_pkg::*;

    localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);
    localparam logic [WIDTH-1:0] THREE = WIDTH'(3);
    localparam logic [WIDTH-1:0] ZERO  = '0;
    localparam logic [WIDTH-1:0] ALL1  = '1;
    localparam logic [WIDTH-1:0] MSB   = ONE << (WIDTH-1);

    logic [WIDTH-1:0] raw;
    logic [WIDTH-1:0] pow2_hit;

    // one detector per bit position: a holds exactly that single bit
    for (genvar k = 0; k < WIDTH; k++) begin : g_pow2
        localparam logic [WIDTH-1:0] PATTERN = ONE << k;
        assign pow2_hit[k] = (a == PATTERN);
    end

    assign raw = a + b;

    // apply the selected corruption to the true sum
    always_comb begin
        sum = raw;
        unique case (mode)
            FM_CLEAN: sum = raw;
            FM_ONE:   if (a == ONE && b == ONE) sum = THREE;
            FM_POW2:  if (a == b && (|pow2_hit)) sum = raw ^ MSB;
            FM_EDGE:  if (b == ALL1 && (a == ZERO || a == ALL1)) sum = raw ^ ONE;
            default:  sum = raw;
        endcase
    end

endmodule

// File: rtl/sweep_counter.sv
// Operand counter for the sweep. It clears on reset and advances by one on
// each step request, and it flags the all-ones value. Wrapping is never
// requested by the controller.
module sweep_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] value,
    output logic          at_last
);
    // hold or advance the presented pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end

    assign at_last = &value;

endmodule

// File: rtl/sweep_ctrl.sv
// Sweep sequencer: idle -> sweep -> (pause on mismatch -> sweep) -> end.
// It asks the counter to step after a passing non-final pair, or on resume
// from a non-final pair. Assumes go is a synchronous pulse.
module sweep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic miscmp,
    input  logic at_last,
    output logic step,
    output logic sweeping,
    output logic fault_seen
);
    import sweep_pkg::*;

    sweep_state_t state, state_nx;

    // next-state and step decision
    always_comb begin
        state_nx = state;
        step     = 1'b0;
        unique case (state)
            ST_IDLE:  if (go) state_nx = ST_SWEEP;
            ST_SWEEP: begin
                if (miscmp) begin
                    state_nx = ST_PAUSE;
                end else if (at_last) begin
                    state_nx = ST_END;
                end else begin
                    step = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (go) begin
                    if (at_last) begin
                        state_nx = ST_END;
                    end else begin
                        state_nx = ST_SWEEP;
                        step     = 1'b1;
                    end
                end
            end
            ST_END:   state_nx = ST_END;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign sweeping   = (state == ST_SWEEP);
    assign fault_seen = (state == ST_PAUSE);

endmodule

// File: rtl/adder_sweep_tester.sv
// Top of the exhaustive adder tester. It joins the operand counter, the
// adder under test, a reference sum and the sequencer. One pair is checked
// per sweeping cycle, and a mismatch halts on the failing pair.
module adder_sweep_tester #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [1:0]       fault_sel,
    output logic [WIDTH-1:0] op_a,
    output logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum_out,
    output logic             fault_seen,
    output logic             sweeping
);
    localparam int CW = 2 * WIDTH;

    logic [CW-1:0]    pair;
    logic             at_last;
    logic             step;
    logic [WIDTH-1:0] ref_sum;
    logic             miscmp;

    sweep_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .value   (pair),
        .at_last (at_last)
    );

    assign op_a = pair[CW-1:WIDTH];
    assign op_b = pair[WIDTH-1:0];

    faulty_adder #(.WIDTH(WIDTH)) u_add (
        .a    (op_a),
        .b    (op_b),
        .mode (fault_sel),
        .sum  (sum_out)
    );

    // reference sum and comparison against the adder under test
    assign ref_sum = op_a + op_b;
    assign miscmp  = (sum_out != ref_sum);

    sweep_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .miscmp     (miscmp),
        .at_last    (at_last),
        .step       (step),
        .sweeping   (sweeping),
        .fault_seen (fault_seen)
    );

endmodule

// File: rtl/sweep_checker.sv
// Temporal checks on the tester's ports. Bound into every instance of
// adder_sweep_tester.
module sweep_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [1:0]       fault_sel,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] sum_out,
    input logic             fault_seen,
    input logic             sweeping
);
    logic [2*WIDTH-1:0] cur;
    logic [WIDTH-1:0]   ref_sum;
    logic               last;

    assign cur     = {op_a, op_b};
    assign ref_sum = op_a + op_b;
    assign last    = &cur;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (cur == '0 && !sweeping && !fault_seen)); // R1
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(sweeping && fault_seen)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (sweeping && sum_out == ref_sum && !last) |=> (sweeping && cur == $past(cur) + 1'b1)); // R3
    AST_HALT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n) (sweeping && sum_out != ref_sum) |=> (fault_seen && !sweeping && $stable(cur))); // R4
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fault_seen && !go) |=> (fault_seen && $stable(cur) && $stable(sum_out))); // R5
    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (fault_seen && go) |=> !fault_seen); // R6
    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n) (sweeping && last && sum_out == ref_sum) |=> (!sweeping && !fault_seen)); // R7
    AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!sweeping && !fault_seen && last) |=> (!sweeping && !fault_seen && last)); // R7
    AST_CLEAN_MODE: assert property (@(posedge clk) disable iff (!rst_n) (fault_sel == 2'd0) |-> (sum_out == ref_sum)); // R9
    AST_ONE_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (fault_sel == 2'd1 && !(op_a == WIDTH'(1) && op_b == WIDTH'(1))) |-> (sum_out == ref_sum)); // R10

endmodule

bind adder_sweep_tester sweep_checker #(.WIDTH(WIDTH)) u_sweep_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .fault_sel  (fault_sel),
    .op_a       (op_a),
    .op_b       (op_b),
    .sum_out    (sum_out),
    .fault_seen (fault_seen),
    .sweeping   (sweeping)
);

// File: tb/adder_sweep_tester_tb.sv
// Bench: reduced width, a behavioural model compared on every cycle, and
// directed go pulses for each fault pattern.
module adder_sweep_tester_tb;
    localparam int  W    = 4;
    localparam int  MASK = (1 << W) - 1;
    localparam int  MAXI = (1 << (2 * W)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic [1:0]   fault_sel = 2'd0;
    logic [W-1:0] op_a, op_b, sum_out;
    logic         fault_seen, sweeping;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    // behavioural model: 0 idle, 1 sweeping, 2 halted, 3 finished
    int m_st  = 0;
    int m_idx = 0;

    adder_sweep_tester #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .fault_sel  (fault_sel),
        .op_a       (op_a),
        .op_b       (op_b),
        .sum_out    (sum_out),
        .fault_seen (fault_seen),
        .sweeping   (sweeping)
    );

    always #5 clk = ~clk;

    function automatic int exp_sum(input int a, input int b, input int m);
        int s;
        s = (a + b) & MASK;
        if (m == 1 && a == 1 && b == 1) s = 3;
        if (m == 2 && a == b && a != 0 && (a & (a - 1)) == 0) s = s ^ (1 << (W - 1));
        if (m == 3 && b == MASK && (a == 0 || a == MASK)) s = s ^ 1;
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // model update on each rising edge from the inputs applied
    always @(posedge clk) begin
        int a, b;
        a = m_idx >> W;
        b = m_idx & MASK;
        if (!rst_n) begin
            m_st  <= 0;
            m_idx <= 0;
        end else begin
            case (m_st)
                0: if (go) m_st <= 1;
                1: begin
                    if (exp_sum(a, b, fault_sel) != ((a + b) & MASK)) m_st <= 2;
                    else if (m_idx == MAXI) m_st <= 3;
                    else m_idx <= m_idx + 1;
                end
                2: if (go) begin
                    if (m_idx == MAXI) m_st <= 3;
                    else begin
                        m_idx <= m_idx + 1;
                        m_st  <= 1;
                    end
                end
                default: m_st <= m_st;
            endcase
        end
    end

    // per-cycle comparison of all outputs against the model
    always @(negedge clk) begin
        string stag;
        if (cmp_on) begin
            stag = (fault_sel == 2'd0) ? "R9" : (fault_sel == 2'd1) ? "R10" :
                   (fault_sel == 2'd2) ? "R11" : "R12";
            chk("R3 operands", int'({op_a, op_b}), m_idx);
            chk("R2 sweeping", int'(sweeping), int'(m_st == 1));
            chk("R4 fault_seen", int'(fault_seen), int'(m_st == 2));
            chk(stag, int'(sum_out), exp_sum(m_idx >> W, m_idx & MASK, fault_sel));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            wrap_up();
        end
    end

    task automatic run_mode(input int m, input int exp_halts);
        int halts, runcyc, prev;
        bit resumed, r8_pend;
        string htag;
        halts = 0; runcyc = 0; prev = 0; resumed = 0; r8_pend = 0;
        fault_sel = m[1:0];
        rst_n = 1'b0;
        go = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        chk("R1 reset operands", int'({op_a, op_b}), 0);
        chk("R1 reset flags", int'({sweeping, fault_seen}), 0);
        @(negedge clk);
        chk("R2 idle without go", int'(sweeping), 0);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R2 start on go", int'(sweeping), 1);
        forever begin
            go = 1'b0;
            if (resumed) begin
                resumed = 0;
                chk("R6 error cleared", int'(fault_seen), 0);
                if (sweeping) chk("R6 next pair", int'({op_a, op_b}), prev + 1);
                else chk("R6 finish from last", prev, MAXI);
            end
            if (r8_pend) begin
                r8_pend = 0;
                chk("R8 go while sweeping", int'({op_a, op_b}), prev + 1);
            end
            if (sweeping) begin
                runcyc++;
                if (m == 0 && runcyc == 5) begin
                    prev = int'({op_a, op_b});
                    r8_pend = 1;
                    go = 1'b1;
                end
            end else if (fault_seen) begin
                halts++;
                prev = int'({op_a, op_b});
                repeat (2) @(negedge clk);
                chk("R5 operands held", int'({op_a, op_b}), prev);
                chk("R5 still halted", int'(fault_seen), 1);
                resumed = 1;
                go = 1'b1;
            end else begin
                break;
            end
            @(negedge clk);
        end
        htag = (m == 0) ? "R9 halts" : (m == 1) ? "R10 halts" : (m == 2) ? "R11 halts" : "R12 halts";
        chk(htag, halts, exp_halts);
        chk("R13 sweeping cycles", runcyc, MAXI + 1);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        chk("R7 stays finished", int'({sweeping, fault_seen}), 0);
        chk("R7 operands all ones", int'({op_a, op_b}), MAXI);
        cmp_on = 1'b0;
    endtask

    initial begin
        run_mode(0, 0);
        run_mode(1, 1);
        run_mode(2, W);
        run_mode(3, 2);
        wrap_up();
    end

endmodule